// File: doc/BRIEF.md
# Circular-Window Memory Write Port

This block turns an address-driven memory controller into a push-only circular queue. The user side presents 32-bit words through a valid/ready push interface. A small internal queue absorbs rate differences toward the memory side. A packer joins each pair of words into one 64-bit beat. Each beat is issued as a write request that carries an address, the data and a valid/ready handshake.

The write address comes from a progressive counter, so no address is computed per access. It starts at a programmable first address and moves up by one beat for each accepted request. After the request at the programmable last address, it returns to the first address, so the window fills circularly. A running count of committed beats is output. Read ports compare it against their own counts to judge occupancy, and it is never cleared at a wrap. One clock is used throughout. Reset is synchronous and active high.

Top module: `circ_wr_port`

## Requirements
- R1: `in_ready` is high exactly while the internal queue holds fewer than `FIFO_DEPTH` words. A word is taken only on a cycle with `in_valid && in_ready`. While `in_ready` is low, `in_valid` and `in_data` have no effect.
- R2: Two consecutive accepted words form one beat: the earlier word in `req_data[31:0]`, the later word in `req_data[63:32]`. A single unpaired word raises no request.
- R3: After reset the first request carries `cfg_start`. Each committed request at an address other than `cfg_end` advances the address by one.
- R4: After a request is committed at `cfg_end`, the next request carries `cfg_start`.
- R5: With `req_ready` held low, the port accepts exactly `FIFO_DEPTH + 3` words before `in_ready` drops: the queue, one parked half-beat, and one pending beat. Word order is preserved when draining.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` stay unchanged. A request completes only on a cycle with `req_valid && req_ready`.
- R7: `beat_count` rises by exactly one per committed request and is not cleared when the address wraps.
- R8: Synchronous reset loads the address with `cfg_start`, clears `beat_count`, drops `req_valid`, empties the queue and discards any unpaired word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_start | input | ADDR_W | First beat address of the window |
| cfg_end | input | ADDR_W | Last beat address of the window |
| in_valid | input | 1 | Push request from the user |
| in_data | input | 32 | Word to push |
| in_ready | output | 1 | Queue can take a word |
| req_valid | output | 1 | Write request pending |
| req_ready | input | 1 | Controller accepts the request |
| req_addr | output | ADDR_W | Beat address of the request |
| req_data | output | 64 | Packed beat |
| beat_count | output | CNT_W | Committed beats since reset |

## Verification
The bench builds the block with a four-word queue, an 8-bit address and a 16-bit count. A three-beat window from address 5 to 7 therefore wraps twice within eight beats, and the queue fills after only seven pushes. The small depth puts the back-pressure limit and the ignored pushes at a full queue within a few cycles. A later reset reprograms the window to addresses 2 and 3, which checks that the address reload follows the new start rather than a fixed value.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int WORD_W = 32;
  localparam int BEAT_W = 2 * WORD_W;

  // Next beat address inside a circular window.
  function automatic logic [31:0] wrap_next(logic [31:0] cur, logic [31:0] first, logic [31:0] last);
    return (cur == last) ? first : cur + 32'd1;
  endfunction

  // Earlier word goes low, later word goes high.
  function automatic logic [BEAT_W-1:0] pack_pair(logic [WORD_W-1:0] early, logic [WORD_W-1:0] late);
    return {late, early};
  endfunction
endpackage

// File: rtl/cwp_fifo.sv
module cwp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wr_data,
  input  logic             pop,
  output logic [W-1:0]     rd_data,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      level <= level + LVL_W'(1);
      else if (pop && !push) level <= level - LVL_W'(1);
    end
  end
endmodule

// File: rtl/cwp_packer.sv
module cwp_packer
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] word,
  output logic              pop,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [BEAT_W-1:0] req_data,
  output logic              commit
);
  logic              half_q;
  logic [WORD_W-1:0] low_q;

  assign commit = req_valid && req_ready;
  // A word may move when it parks as a half-beat, or when it completes a
  // beat and the beat slot is free or emptying this cycle.
  assign pop = word_avail && (!half_q || !req_valid || req_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q    <= 1'b0;
      low_q     <= '0;
      req_valid <= 1'b0;
      req_data  <= '0;
    end else begin
      if (commit) req_valid <= 1'b0;
      if (pop) begin
        if (!half_q) begin
          low_q  <= word;
          half_q <= 1'b1;
        end else begin
          req_data  <= pack_pair(low_q, word);
          req_valid <= 1'b1;
          half_q    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cwp_addr_gen.sv
module cwp_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic              commit,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  beat_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= cfg_start;
      beat_count <= '0;
    end else if (commit) begin
      addr       <= ADDR_W'(cwp_pkg::wrap_next(32'(addr), 32'(cfg_start), 32'(cfg_end)));
      beat_count <= beat_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/circ_wr_port.sv
module circ_wr_port
  import cwp_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BEAT_W-1:0] req_data,
  output logic [CNT_W-1:0]  beat_count
);
  logic              push_w, pop_w, full_w, empty_w, commit_w;
  logic [WORD_W-1:0] head_w;
  logic [LVL_W-1:0]  fifo_level_w;

  assign in_ready = !full_w;
  assign push_w   = in_valid && in_ready;

  cwp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_w), .wr_data(in_data), .pop(pop_w),
    .rd_data(head_w), .full(full_w), .empty(empty_w), .level(fifo_level_w)
  );

  cwp_packer u_packer (
    .clk(clk), .rst(rst), .word_avail(!empty_w), .word(head_w), .pop(pop_w),
    .req_ready(req_ready), .req_valid(req_valid), .req_data(req_data),
    .commit(commit_w)
  );

  cwp_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .commit(commit_w), .addr(req_addr), .beat_count(beat_count)
  );
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_start,
  input logic [ADDR_W-1:0] cfg_end,
  input logic              in_valid,
  input logic              in_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       req_data,
  input logic [CNT_W-1:0]  beat_count,
  input logic              commit,
  input logic [LVL_W-1:0]  fifo_level
);
  logic rst_prev_q = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_prev_q)
      AST_RESET_STATE: assert (beat_count == '0 && !req_valid && in_ready && fifo_level == '0); // R8
    rst_prev_q <= rst;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH)); // R5
  AST_BLOCKED_PUSH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> fifo_level <= $past(fifo_level)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_data)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (commit && req_addr != cfg_end) |=> req_addr == $past(req_addr) + ADDR_W'(1)); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (commit && req_addr == cfg_end) |=> req_addr == $past(cfg_start)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    commit |=> beat_count == $past(beat_count) + CNT_W'(1)); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(beat_count)); // R7
endmodule

bind circ_wr_port cwp_checker #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_cwp_checker (
  .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_end(cfg_end),
  .in_valid(in_valid), .in_ready(in_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
  .beat_count(beat_count), .commit(commit_w), .fifo_level(fifo_level_w)
);

// File: tb/test_circ_wr_port.sv
module test_circ_wr_port;
  localparam int AW = 8;
  localparam int DEPTH = 4;
  localparam int CW = 16;
  localparam int NV = 8;
  // {early word, late word, stall cycles}
  localparam logic [71:0] VECS [NV] = '{
    {32'h1111_0001, 32'h2222_0002, 8'd0},
    {32'hDEAD_BEEF, 32'h0BAD_F00D, 8'd2},
    {32'h0000_0000, 32'hFFFF_FFFF, 8'd1},
    {32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'd3},
    {32'h1234_5678, 32'h9ABC_DEF0, 8'd0},
    {32'h8000_0000, 32'h0000_0001, 8'd4},
    {32'hCAFE_0007, 32'hFACE_0008, 8'd1},
    {32'h0F0F_0F0F, 32'hF0F0_F0F0, 8'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] cfg_start = 8'd5, cfg_end = 8'd7;
  logic in_valid = 1'b0, req_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, req_valid;
  logic [AW-1:0] req_addr;
  logic [63:0] req_data;
  logic [CW-1:0] beat_count;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  circ_wr_port #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH), .CNT_W(CW)) i_circ_wr_port (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .beat_count(beat_count)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w);
    bit acc;
    in_valid = 1'b1; in_data = w;
    do begin acc = in_ready; tick(); end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 20 && !req_valid; k++) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; req_ready = 1'b0; in_valid = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    if (a == cfg_end) return cfg_start;
    return a + 8'd1;
  endfunction

  initial begin
    logic [AW-1:0] exp_addr;
    logic [CW-1:0] exp_cnt;
    logic [31:0] fw [8];
    int got;

    do_reset();
    // R8: reset state
    check(req_addr == 8'd5, "R8 addr after reset", 64'(req_addr), 64'd5);
    check(beat_count == '0, "R8 count after reset", 64'(beat_count), 64'd0);
    check(!req_valid && in_ready, "R8 valid/ready after reset", {62'd0, req_valid, in_ready}, 64'd1);

    // vector walk: packing, address step and wrap, hold, count
    exp_addr = cfg_start; exp_cnt = '0;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w0, w1;
      int st;
      w0 = VECS[i][71:40]; w1 = VECS[i][39:8]; st = int'(VECS[i][7:0]);
      push(w0); push(w1);
      wait_req();
      check(req_valid, "R2 request raised", 64'(req_valid), 64'd1);
      check(req_data == {w1, w0}, "R2 packing order", req_data, {w1, w0});
      if (i > 0 && exp_addr == cfg_start)
        check(req_addr == exp_addr, "R4 wrap to start", 64'(req_addr), 64'(exp_addr));
      else
        check(req_addr == exp_addr, "R3 address step", 64'(req_addr), 64'(exp_addr));
      for (int s = 0; s < st; s++) begin
        tick();
        check(req_valid && req_data == {w1, w0} && req_addr == exp_addr,
              "R6 hold under stall", req_data, {w1, w0});
        check(beat_count == exp_cnt, "R6 no commit while stalled", 64'(beat_count), 64'(exp_cnt));
      end
      req_ready = 1'b1; tick(); req_ready = 1'b0;
      exp_cnt++; exp_addr = step(exp_addr);
      check(beat_count == exp_cnt, "R7 count per commit", 64'(beat_count), 64'(exp_cnt));
      check(!req_valid, "R6 request completes", 64'(req_valid), 64'd0);
    end
    check(beat_count == 16'd8, "R7 count not cleared by wrap", 64'(beat_count), 64'd8);

    // R2: a lone word raises no request
    do_reset();
    push(32'h0000_AAAA);
    for (int k = 0; k < 5; k++) tick();
    check(!req_valid, "R2 lone word no request", 64'(req_valid), 64'd0);
    push(32'h0000_BBBB);
    wait_req();
    check(req_data == 64'h0000_BBBB_0000_AAAA, "R2 pair after lone word", req_data, 64'h0000_BBBB_0000_AAAA);

    // R5 / R1: capacity, ignored pushes while full, order on drain
    do_reset();
    for (int k = 0; k < 8; k++) fw[k] = 32'hC000_0000 + 32'(k);
    for (int k = 0; k < DEPTH + 3; k++) push(fw[k]);
    tick(); tick(); tick();
    check(!in_ready, "R5 ready drops after DEPTH+3 words", 64'(in_ready), 64'd0);
    in_valid = 1'b1; in_data = 32'hBAD0_BAD0;
    tick(); tick(); tick();
    in_valid = 1'b0;
    check(!in_ready, "R1 still full with blocked push", 64'(in_ready), 64'd0);
    req_ready = 1'b1; got = 0;
    for (int k = 0; k < 40 && got < 3; k++) begin
      if (req_valid) begin
        check(req_data == {fw[2*got+1], fw[2*got]}, "R5 drain order", req_data, {fw[2*got+1], fw[2*got]});
        got++;
      end
      tick();
    end
    check(got == 3, "R5 three beats drained", 64'(got), 64'd3);
    req_ready = 1'b0;
    push(fw[7]);
    wait_req();
    check(req_data == {fw[7], fw[6]}, "R1 blocked word not taken", req_data, {fw[7], fw[6]});
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    check(beat_count == 16'd4, "R7 count after drain", 64'(beat_count), 64'd4);

    // R8: reset discards a half-beat and reloads a new start
    push(32'h7777_7777);
    tick();
    cfg_start = 8'd2; cfg_end = 8'd3;
    do_reset();
    check(req_addr == 8'd2, "R8 reload new start", 64'(req_addr), 64'd2);
    check(beat_count == '0 && !req_valid, "R8 cleared", 64'(beat_count), 64'd0);
    push(32'h0000_0011); push(32'h0000_0022);
    wait_req();
    check(req_data == 64'h0000_0022_0000_0011, "R8 half-beat discarded", req_data, 64'h0000_0022_0000_0011);
    check(req_addr == 8'd2, "R3 first address after reset", 64'(req_addr), 64'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule